// File: doc/BRIEF.md
# Cache Port Send and Retry Controller

This block sits on one side of a cache port and drives a valid/ready link that may refuse a packet and later raise a retry pulse. It has three sources of outgoing traffic. The first is a small drain FIFO of responses that could not be sent at once. The second is a fresh response from the response producer. The third is a request from either the miss handler (memory side) or the coherence handler (CPU side), chosen by a parameter. The fixed priority is queued responses first, then a direct response, then a request. Once the link refuses a packet, the block stops sending until the retry arrives.

On the incoming side, the block gates requests while the cache core holds it blocked. It remembers that a requester was turned away and sends one retry pulse upstream when the block is released. On the CPU side, a cacheable invalidate or upgrade that carries no data transfer is accepted at once, even while blocked. It is marked satisfied and produces no response.

Top module: `cport_retry_ctrl`

## Requirements
- R1: After reset, `out_valid_o` and `up_retry_o` are 0 and `rsp_ready_o` is 1.
- R2: A response accepted while the FIFO is empty and the port is not waiting is presented on the link in the same cycle, with `out_kind_o` = 2'b01 and its data.
- R3: A response flagged with `rsp_nack_i` is sent with `out_kind_o` = 2'b10. A request is sent with `out_kind_o` = 2'b00.
- R4: A refused direct response is stored in the FIFO and the port enters the waiting state. While waiting, `out_valid_o` stays 0 in every cycle without `link_retry_i`.
- R5: A response that arrives while the FIFO is non-empty or the port is waiting is appended to the FIFO and not sent. Queued responses leave in arrival order.
- R6: On a retry, and in every later send cycle, the FIFO head is sent before any direct response or request. A request is presented only when the FIFO is empty and no direct response is being sent.
- R7: After an accepted send, the next pending item is presented in the very next cycle.
- R8: `src_gnt_o` marks the cycle a request is presented. `src_ok_o` is 1 in that same cycle exactly when the link accepts it.
- R9: A retry with nothing to send clears the waiting state and sends nothing. A later response then goes out directly.
- R10: While `hold_i` is 1, an incoming request (`in_req_i`) is refused. In that case, the cycle after `hold_i` falls, `up_retry_o` pulses for exactly one cycle. A release with no refused request gives no pulse.
- R11: On the CPU side, an incoming request with `in_inval_i` set is accepted even while held. `satisfied_o` pulses and nothing is sent on the link.
- R12: When the FIFO holds DEPTH entries, `rsp_ready_o` is 0 until an entry drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Cache core holds the port blocked |
| in_valid_i | input | 1 | Incoming packet valid |
| in_req_i | input | 1 | Incoming packet is a request |
| in_inval_i | input | 1 | Incoming request is a cacheable invalidate/upgrade with no data |
| in_ready_o | output | 1 | Incoming packet accepted |
| satisfied_o | output | 1 | Invalidate/upgrade accepted and satisfied without a response |
| up_retry_o | output | 1 | One-cycle retry pulse to the upstream requester |
| rsp_valid_i | input | 1 | Response producer has a response |
| rsp_data_i | input | DATA_W | Response payload |
| rsp_nack_i | input | 1 | Response line was negatively acknowledged |
| rsp_ready_o | output | 1 | Response accepted (FIFO not full) |
| src_req_i | input | 1 | Miss or coherence source requests a send |
| src_data_i | input | DATA_W | Request payload |
| src_gnt_o | output | 1 | Request presented on the link this cycle |
| src_ok_o | output | 1 | Presented request accepted by the link |
| out_valid_o | output | 1 | Link packet valid |
| out_data_o | output | DATA_W | Link packet payload |
| out_kind_o | output | 2 | 00 request, 01 response success, 10 response NACK |
| out_ready_i | input | 1 | Link accepts the packet |
| link_retry_i | input | 1 | Link retry pulse |

## Verification
A stuck waiting flag shows up at once as a link that stays silent after a retry, or that sends while it should stall. A corrupted FIFO pointer shows within a few cycles, as responses that come out reordered, come out twice, or never come out. A wrong arbitration choice is visible in the same cycle as a request that overtakes a queued response on `out_kind_o`. A lost must-retry flag shows one cycle after `hold_i` falls, as a missing `up_retry_o` pulse.

// File: rtl/cport_pkg.sv
package cport_pkg;
   typedef enum logic [1:0] {
      PK_REQ      = 2'b00,
      PK_RSP_OK   = 2'b01,
      PK_RSP_NACK = 2'b10
   } pk_kind_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_HEAD = 2'd1,
      SEL_RSP  = 2'd2,
      SEL_SRC  = 2'd3
   } sel_e;
endpackage

// File: rtl/cport_fifo.sv
module cport_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] rd_q, wr_q, rd_nxt, wr_nxt;
   logic [CW-1:0] cnt_q;

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign rd_nxt = rd_q + 1'b1;
         assign wr_nxt = wr_q + 1'b1;
      end else begin : g_wrap
         assign rd_nxt = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
         assign wr_nxt = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) begin
            store[wr_q] <= push_data;
            wr_q        <= wr_nxt;
         end
         if (pop) rd_q <= rd_nxt;
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign head  = store[rd_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign count = cnt_q;
endmodule

// File: rtl/cport_gate.sv
module cport_gate #(
   parameter int IS_CPU = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic in_valid_i,
   input  logic in_req_i,
   input  logic in_inval_i,
   output logic in_ready_o,
   output logic satisfied_o,
   output logic up_retry_o
);
   localparam logic FAST_EN = (IS_CPU != 0);

   logic fast, refuse, hold_q, owe_q;

   assign fast        = FAST_EN & in_valid_i & in_req_i & in_inval_i;
   assign refuse      = in_valid_i & in_req_i & hold_i & ~fast;
   assign in_ready_o  = fast | ~(in_req_i & hold_i);
   assign satisfied_o = fast;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q     <= 1'b0;
         owe_q      <= 1'b0;
         up_retry_o <= 1'b0;
      end else begin
         hold_q     <= hold_i;
         up_retry_o <= hold_q & ~hold_i & owe_q;
         if (refuse)                  owe_q <= 1'b1;
         else if (!hold_q && hold_i)  owe_q <= 1'b0;
         else if (hold_q && !hold_i)  owe_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cport_arb.sv
module cport_arb
   import cport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              waiting_q,
   input  logic              link_retry_i,
   input  logic              fifo_empty,
   input  logic [DATA_W:0]   head,
   input  logic              rsp_take,
   input  logic [DATA_W-1:0] rsp_data_i,
   input  logic              rsp_nack_i,
   input  logic              src_req_i,
   input  logic [DATA_W-1:0] src_data_i,
   input  logic              out_ready_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic [1:0]        out_kind_o,
   output logic              push,
   output logic              pop,
   output logic              src_gnt_o,
   output logic              waiting_d
);
   logic attempt;
   sel_e sel;

   assign attempt = ~waiting_q | link_retry_i;

   always_comb begin
      sel = SEL_NONE;
      if (attempt) begin
         if (!fifo_empty)                      sel = SEL_HEAD;
         else if (rsp_take && !waiting_q)      sel = SEL_RSP;
         else if (src_req_i)                   sel = SEL_SRC;
      end
   end

   always_comb begin
      out_valid_o = (sel != SEL_NONE);
      out_data_o  = src_data_i;
      out_kind_o  = PK_REQ;
      unique case (sel)
         SEL_HEAD: begin
            out_data_o = head[DATA_W-1:0];
            out_kind_o = head[DATA_W] ? PK_RSP_NACK : PK_RSP_OK;
         end
         SEL_RSP: begin
            out_data_o = rsp_data_i;
            out_kind_o = rsp_nack_i ? PK_RSP_NACK : PK_RSP_OK;
         end
         default: ;
      endcase
   end

   assign push      = rsp_take & ~((sel == SEL_RSP) & out_ready_i);
   assign pop       = (sel == SEL_HEAD) & out_ready_i;
   assign src_gnt_o = (sel == SEL_SRC);
   assign waiting_d = attempt ? (out_valid_o & ~out_ready_i) : waiting_q;
endmodule

// File: rtl/cport_retry_ctrl.sv
module cport_retry_ctrl #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   parameter int IS_CPU = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              in_valid_i,
   input  logic              in_req_i,
   input  logic              in_inval_i,
   output logic              in_ready_o,
   output logic              satisfied_o,
   output logic              up_retry_o,
   input  logic              rsp_valid_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   input  logic              rsp_nack_i,
   output logic              rsp_ready_o,
   input  logic              src_req_i,
   input  logic [DATA_W-1:0] src_data_i,
   output logic              src_gnt_o,
   output logic              src_ok_o,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic [1:0]        out_kind_o,
   input  logic              out_ready_i,
   input  logic              link_retry_i
);
   localparam int EW = DATA_W + 1;
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("cport_retry_ctrl: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("cport_retry_ctrl: DEPTH must be at least 2");
      end
   endgenerate

   logic          waiting_q, waiting_d;
   logic          push, pop, fifo_empty, fifo_full, rsp_take;
   logic [EW-1:0] head;
   logic [CW-1:0] fifo_cnt;

   assign rsp_ready_o = ~fifo_full;
   assign rsp_take    = rsp_valid_i & ~fifo_full;
   assign src_ok_o    = src_gnt_o & out_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) waiting_q <= 1'b0;
      else        waiting_q <= waiting_d;
   end

   cport_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data({rsp_nack_i, rsp_data_i}),
      .pop(pop), .head(head), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
   );

   cport_arb #(.DATA_W(DATA_W)) u_arb (
      .waiting_q(waiting_q), .link_retry_i(link_retry_i), .fifo_empty(fifo_empty),
      .head(head), .rsp_take(rsp_take), .rsp_data_i(rsp_data_i), .rsp_nack_i(rsp_nack_i),
      .src_req_i(src_req_i), .src_data_i(src_data_i), .out_ready_i(out_ready_i),
      .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_kind_o(out_kind_o),
      .push(push), .pop(pop), .src_gnt_o(src_gnt_o), .waiting_d(waiting_d)
   );

   cport_gate #(.IS_CPU(IS_CPU)) u_gate (
      .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .in_valid_i(in_valid_i),
      .in_req_i(in_req_i), .in_inval_i(in_inval_i), .in_ready_o(in_ready_o),
      .satisfied_o(satisfied_o), .up_retry_o(up_retry_o)
   );
endmodule

// File: rtl/cport_retry_chk.sv
module cport_retry_chk #(
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hold_i,
   input logic          waiting_q,
   input logic [CW-1:0] fifo_cnt,
   input logic          satisfied_o,
   input logic          in_ready_o,
   input logic          up_retry_o,
   input logic          src_ok_o,
   input logic          out_valid_o,
   input logic [1:0]    out_kind_o,
   input logic          out_ready_i,
   input logic          link_retry_i
);
   // R4
   wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_q && !link_retry_i) |-> !out_valid_o);

   // R4
   refuse_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (!out_valid_o || link_retry_i));

   // R6
   head_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_kind_o == 2'b00) |-> (fifo_cnt == '0));

   // R8
   src_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_ok_o |-> (out_valid_o && out_ready_i && out_kind_o == 2'b00));

   // R10
   retry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_retry_o |=> !up_retry_o);

   // R10
   retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_retry_o |-> (!$past(hold_i) && $past(hold_i, 2)));

   // R11
   satisfied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      satisfied_o |-> in_ready_o);
endmodule

bind cport_retry_ctrl cport_retry_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .waiting_q(waiting_q),
   .fifo_cnt(fifo_cnt), .satisfied_o(satisfied_o), .in_ready_o(in_ready_o),
   .up_retry_o(up_retry_o), .src_ok_o(src_ok_o), .out_valid_o(out_valid_o),
   .out_kind_o(out_kind_o), .out_ready_i(out_ready_i), .link_retry_i(link_retry_i)
);

// File: tb/tb_cport_retry_ctrl.sv
module tb_cport_retry_ctrl;
   logic clk = 1'b0, rst_n = 1'b0;
   logic hold_i = 0, in_valid_i = 0, in_req_i = 0, in_inval_i = 0;
   logic in_ready_o, satisfied_o, up_retry_o;
   logic rsp_valid_i = 0, rsp_nack_i = 0, rsp_ready_o;
   logic [7:0] rsp_data_i = 0, src_data_i = 0, out_data_o;
   logic src_req_i = 0, src_gnt_o, src_ok_o;
   logic out_valid_o, out_ready_i = 1, link_retry_i = 0;
   logic [1:0] out_kind_o;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cport_retry_ctrl #(.DATA_W(8), .DEPTH(4), .IS_CPU(1)) dut (.*);

   typedef struct packed {
      logic rv; logic [7:0] rd; logic rn; logic sr; logic [7:0] sd;
      logic ordy; logic rtry; logic ev; logic [1:0] ek; logic [7:0] ed; logic eok;
   } vec_t;

   localparam vec_t TBL [0:17] = '{
      '{1,8'hA1,0, 0,8'h00, 1,0, 1,2'b01,8'hA1,0}, // R2 direct
      '{1,8'hA2,1, 0,8'h00, 1,0, 1,2'b10,8'hA2,0}, // R3 nack
      '{0,8'h00,0, 1,8'hC1, 1,0, 1,2'b00,8'hC1,1}, // R8 request ok
      '{1,8'hA3,0, 0,8'h00, 0,0, 1,2'b01,8'hA3,0}, // R4 refused
      '{1,8'hA4,0, 0,8'h00, 1,0, 0,2'b00,8'h00,0}, // R5 append while waiting
      '{0,8'h00,0, 1,8'hC2, 1,0, 0,2'b00,8'h00,0}, // R4 stall
      '{0,8'h00,0, 1,8'hC2, 1,1, 1,2'b01,8'hA3,0}, // R6 head first on retry
      '{0,8'h00,0, 1,8'hC2, 1,0, 1,2'b01,8'hA4,0}, // R7 next cycle, order
      '{0,8'h00,0, 1,8'hC2, 1,0, 1,2'b00,8'hC2,1}, // R6 request once empty
      '{1,8'hA5,0, 1,8'hC3, 1,0, 1,2'b01,8'hA5,0}, // R6 response over request
      '{0,8'h00,0, 1,8'hC3, 0,0, 1,2'b00,8'hC3,0}, // R8 refused request
      '{0,8'h00,0, 0,8'h00, 1,1, 0,2'b00,8'h00,0}, // R9 empty retry
      '{1,8'hA6,0, 0,8'h00, 1,0, 1,2'b01,8'hA6,0}, // R9 direct again
      '{1,8'hA7,0, 0,8'h00, 0,0, 1,2'b01,8'hA7,0}, // R4 refused
      '{0,8'h00,0, 0,8'h00, 0,1, 1,2'b01,8'hA7,0}, // R4 refused on retry
      '{0,8'h00,0, 0,8'h00, 1,0, 0,2'b00,8'h00,0}, // R4 still waiting
      '{0,8'h00,0, 0,8'h00, 1,1, 1,2'b01,8'hA7,0}, // R6 retry sends head
      '{0,8'h00,0, 0,8'h00, 1,0, 0,2'b00,8'h00,0}  // R7 idle
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic out_chk(input string tag, input bit ev, input logic [1:0] ek, input logic [7:0] ed);
      chk(out_valid_o == ev, {tag, " valid"}, out_valid_o, ev);
      if (ev) chk({out_kind_o, out_data_o} == {ek, ed}, {tag, " kind/data"},
                  {out_kind_o, out_data_o}, {ek, ed});
   endtask

   task automatic idle();
      rsp_valid_i = 0; src_req_i = 0; link_retry_i = 0; out_ready_i = 1;
      in_valid_i = 0; in_req_i = 0; in_inval_i = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #3;
      // R1 reset state
      chk(out_valid_o == 0, "R1 out_valid", out_valid_o, 0);
      chk(up_retry_o == 0, "R1 up_retry", up_retry_o, 0);
      chk(rsp_ready_o == 1, "R1 rsp_ready", rsp_ready_o, 1);
      @(negedge clk); rst_n = 1;

      for (int i = 0; i < 18; i++) begin
         @(negedge clk);
         rsp_valid_i = TBL[i].rv; rsp_data_i = TBL[i].rd; rsp_nack_i = TBL[i].rn;
         src_req_i = TBL[i].sr; src_data_i = TBL[i].sd;
         out_ready_i = TBL[i].ordy; link_retry_i = TBL[i].rtry;
         #3;
         out_chk($sformatf("R2-table row %0d", i), TBL[i].ev, TBL[i].ek, TBL[i].ed);
         chk(src_ok_o == TBL[i].eok, $sformatf("R8 src_ok row %0d", i), src_ok_o, TBL[i].eok);
      end

      // R12 fill FIFO: first refused direct, then three appended
      @(negedge clk); idle(); rsp_valid_i = 1; rsp_data_i = 8'hB0; out_ready_i = 0;
      for (int k = 1; k < 4; k++) begin
         @(negedge clk); idle(); rsp_valid_i = 1; rsp_data_i = 8'hB0 + 8'(k);
         rsp_nack_i = (k == 2);
      end
      @(negedge clk); idle(); rsp_valid_i = 1; rsp_data_i = 8'hBF; #3;
      chk(rsp_ready_o == 0, "R12 full", rsp_ready_o, 0);
      chk(out_valid_o == 0, "R4 stall full", out_valid_o, 0);
      @(negedge clk); idle(); link_retry_i = 1; #3;
      out_chk("R6 drain B0", 1, 2'b01, 8'hB0);
      chk(rsp_ready_o == 0, "R12 full at pop", rsp_ready_o, 0);
      @(negedge clk); idle(); #3;
      out_chk("R5 drain B1", 1, 2'b01, 8'hB1);
      chk(rsp_ready_o == 1, "R12 space again", rsp_ready_o, 1);
      @(negedge clk); idle(); #3;
      out_chk("R3 drain B2 nack", 1, 2'b10, 8'hB2);
      @(negedge clk); idle(); #3;
      out_chk("R5 drain B3", 1, 2'b01, 8'hB3);
      @(negedge clk); idle(); #3;
      out_chk("R12 nothing extra", 0, 2'b00, 8'h00);

      // R10 refused request while held, then release
      @(negedge clk); idle(); hold_i = 1;
      @(negedge clk); in_valid_i = 1; in_req_i = 1; #3;
      chk(in_ready_o == 0, "R10 refused", in_ready_o, 0);
      @(negedge clk); idle(); hold_i = 0; #3;
      chk(up_retry_o == 0, "R10 no early pulse", up_retry_o, 0);
      @(negedge clk); #3;
      chk(up_retry_o == 1, "R10 pulse", up_retry_o, 1);
      @(negedge clk); #3;
      chk(up_retry_o == 0, "R10 single pulse", up_retry_o, 0);

      // R11 invalidate accepted while held; R10 release without owed retry
      @(negedge clk); hold_i = 1; in_valid_i = 1; in_req_i = 1; in_inval_i = 1; #3;
      chk(in_ready_o == 1, "R11 accepted", in_ready_o, 1);
      chk(satisfied_o == 1, "R11 satisfied", satisfied_o, 1);
      chk(out_valid_o == 0, "R11 no response", out_valid_o, 0);
      @(negedge clk); idle(); #3;
      chk(satisfied_o == 0, "R11 pulse ends", satisfied_o, 0);
      @(negedge clk); hold_i = 0;
      @(negedge clk); #3;
      chk(up_retry_o == 0, "R10 no owed pulse", up_retry_o, 0);
      @(negedge clk); #3;
      chk(out_valid_o == 0, "R11 link quiet", out_valid_o, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      done = 1;
      $finish;
   end
endmodule